// File: doc/BRIEF.md
# Pixel Controller Register and Transmit FIFO Front-End

This block sits between a 32-bit register bus and a pixel serializer. Software writes configuration words for the frame length, the colour order, the bit timing and the latch timing. The block breaks those words into plain configuration outputs for the serializer. Pixel words written to the data port go into a transmit FIFO, and the FIFO feeds the serializer over a valid/ready stream.

The same register space holds the DMA and interrupt settings and a status word. The status word shows the live FIFO fill level beside two sticky flags, which software clears by writing 1 to them.

The CPU-request flag is raised while a transfer runs without DMA and the FIFO has drained to the trigger level. The transfer-finish flag is raised when the serializer reports the end of a frame. A separate DMA request line is asserted while DMA is enabled and the FIFO has at least the trigger level of free words.

The pixel stream follows valid/ready rules. A word leaves the FIFO on a cycle where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the offered word and `pix_valid` hold still. The write port has no back-pressure: software or DMA must respect the fill level, and any excess is dropped.

Top module: `pixfe_top`

## Requirements
- R1: After reset, every register reads 0, the FIFO is empty, and `pix_valid`, `irq` and `dma_req` are low.
- R2: Only the defined field bits of each register are stored, and all other bits read as 0. The register offsets and fields are:
  - control (0x00): length in bits 28:16, colour order in bits 8:6, run in bit 0;
  - bit timing (0x04): one-high in bits 26:21, one-low in bits 20:16, zero-high in bits 10:6, zero-low in bits 5:0;
  - latch timing (0x0C): latch time in bits 28:16, pixel count in bits 9:0;
  - DMA control (0x18): DMA on in bit 5, trigger level in bits 4:0;
  - interrupt enable (0x1C): global in bit 5, CPU-request in bit 1, finish in bit 0.
  
  Unmapped offsets and the data port (0x14) read 0.
- R3: A write to 0x14 pushes the write data into a 32-word FIFO. A write while the FIFO is full is dropped. Status (0x20) bits 15:10 show the current number of words in the FIFO.
- R4: `pix_valid` is high only while the run bit is set and the FIFO is non-empty. Words leave in write order, one per cycle with `pix_valid` and `pix_ready` both high. While `pix_ready` is low, `pix_valid` and `pix_data` hold.
- R5: A control write that sets the run bit while it is clear empties the FIFO.
- R6: Status bit 1 (CPU request) is set one cycle after a cycle in which the run bit is set, DMA is off, and the fill level is at or below the trigger level.
- R7: A one-cycle pulse on `xfer_done` sets status bit 0 (finish) and clears the run bit on the next edge.
- R8: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R9: `irq` is high exactly when the global enable is set and at least one flag is set together with its own enable.
- R10: `dma_req` is high exactly when DMA is on, the run bit is set, and the free words (32 minus the fill level) are at least the trigger level.
- R11: The configuration outputs carry the stored field values of the control, bit-timing and latch-timing registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pix_valid | output | 1 | FIFO head word is offered |
| pix_data | output | 32 | FIFO head word |
| pix_ready | input | 1 | Serializer accepts the offered word |
| xfer_done | input | 1 | Serializer pulse at the end of a frame |
| cfg_run | output | 1 | Run bit |
| cfg_len | output | 13 | Frame length in pixels |
| cfg_order | output | 3 | Colour order code |
| cfg_t1h | output | 6 | One-bit high time |
| cfg_t1l | output | 5 | One-bit low time |
| cfg_t0h | output | 5 | Zero-bit high time |
| cfg_t0l | output | 6 | Zero-bit low time |
| cfg_tlatch | output | 13 | Latch (reset) time |
| cfg_npix | output | 10 | Pixel count |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest case to reach is the full FIFO while the run bit is set. Reaching it needs the serializer to stall and more than 32 writes to arrive.

The stimulus holds `pix_ready` low, then starts a run, which empties the FIFO. It then writes 34 words, so the last two must be dropped. Draining the FIFO afterwards must return exactly the first 32 words in order.

The DMA threshold edge is approached one word at a time. The CPU-request flag is cleared only after `xfer_done` has ended the run, because while the run continues its set condition would immediately restore it.

// File: rtl/pixfe_pkg.sv
package pixfe_pkg;
  localparam int AW = 6;
  localparam int DW = 32;

  localparam logic [AW-1:0] ADR_CTRL  = 6'h00;
  localparam logic [AW-1:0] ADR_BITT  = 6'h04;
  localparam logic [AW-1:0] ADR_LATCH = 6'h0C;
  localparam logic [AW-1:0] ADR_DATA  = 6'h14;
  localparam logic [AW-1:0] ADR_DMAC  = 6'h18;
  localparam logic [AW-1:0] ADR_IEN   = 6'h1C;
  localparam logic [AW-1:0] ADR_STAT  = 6'h20;

  typedef struct packed {
    logic [12:0] len;
    logic [2:0]  order;
    logic        run;
    logic [5:0]  t1h;
    logic [4:0]  t1l;
    logic [4:0]  t0h;
    logic [5:0]  t0l;
    logic [12:0] tlatch;
    logic [9:0]  npix;
    logic        dma_on;
    logic [4:0]  trig;
    logic        ie_glob;
    logic        ie_req;
    logic        ie_fin;
  } cfg_t;
endpackage

// File: rtl/pixfe_fifo.sv
module pixfe_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] level;
  logic          do_push, do_pop;

  assign empty_o = (level == '0);
  assign full_o  = (level == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rptr];
  assign level_o = level;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush_i) mem[wptr] <= push_data_i;
  end
endmodule

// File: rtl/pixfe_regs.sv
module pixfe_regs
  import pixfe_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          xfer_done,
  input  logic [LW-1:0] level_i,
  input  logic          flag_req_i,
  input  logic          flag_fin_i,
  output cfg_t          cfg_o,
  output logic          flush_o,
  output logic          push_o,
  output logic          stat_wr_o
);
  cfg_t cfg;
  logic wr_ctrl;

  assign wr_ctrl   = bus_wr && (bus_addr == ADR_CTRL);
  assign flush_o   = wr_ctrl && bus_wdata[0] && !cfg.run;
  assign push_o    = bus_wr && (bus_addr == ADR_DATA);
  assign stat_wr_o = bus_wr && (bus_addr == ADR_STAT);
  assign cfg_o     = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.len   <= bus_wdata[28:16];
        cfg.order <= bus_wdata[8:6];
        cfg.run   <= bus_wdata[0];
      end else if (xfer_done) begin
        cfg.run <= 1'b0;
      end
      if (bus_wr && bus_addr == ADR_BITT) begin
        cfg.t1h <= bus_wdata[26:21];
        cfg.t1l <= bus_wdata[20:16];
        cfg.t0h <= bus_wdata[10:6];
        cfg.t0l <= bus_wdata[5:0];
      end
      if (bus_wr && bus_addr == ADR_LATCH) begin
        cfg.tlatch <= bus_wdata[28:16];
        cfg.npix   <= bus_wdata[9:0];
      end
      if (bus_wr && bus_addr == ADR_DMAC) begin
        cfg.dma_on <= bus_wdata[5];
        cfg.trig   <= bus_wdata[4:0];
      end
      if (bus_wr && bus_addr == ADR_IEN) begin
        cfg.ie_glob <= bus_wdata[5];
        cfg.ie_req  <= bus_wdata[1];
        cfg.ie_fin  <= bus_wdata[0];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADR_CTRL:  bus_rdata = {3'b0, cfg.len, 7'b0, cfg.order, 5'b0, cfg.run};
      ADR_BITT:  bus_rdata = {5'b0, cfg.t1h, cfg.t1l, 5'b0, cfg.t0h, cfg.t0l};
      ADR_LATCH: bus_rdata = {3'b0, cfg.tlatch, 6'b0, cfg.npix};
      ADR_DMAC:  bus_rdata = {26'b0, cfg.dma_on, cfg.trig};
      ADR_IEN:   bus_rdata = {26'b0, cfg.ie_glob, 3'b0, cfg.ie_req, cfg.ie_fin};
      ADR_STAT:  bus_rdata = {16'b0, 6'(level_i), 8'b0, flag_req_i, flag_fin_i};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pixfe_evt.sv
module pixfe_evt
  import pixfe_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg_i,
  input  logic [LW-1:0] level_i,
  input  logic          xfer_done,
  input  logic          stat_wr_i,
  input  logic [1:0]    stat_w1c_i,
  output logic          flag_req_o,
  output logic          flag_fin_o,
  output logic          irq_o,
  output logic          dma_req_o
);
  logic set_req, free_ok;

  assign set_req = cfg_i.run && !cfg_i.dma_on && (32'(level_i) <= 32'(cfg_i.trig));
  assign free_ok = (32'(DEPTH) - 32'(level_i)) >= 32'(cfg_i.trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_req_o <= 1'b0;
      flag_fin_o <= 1'b0;
    end else begin
      if (set_req)                         flag_req_o <= 1'b1;
      else if (stat_wr_i && stat_w1c_i[1]) flag_req_o <= 1'b0;
      if (xfer_done)                       flag_fin_o <= 1'b1;
      else if (stat_wr_i && stat_w1c_i[0]) flag_fin_o <= 1'b0;
    end
  end

  assign irq_o = cfg_i.ie_glob &&
                 ((flag_req_o && cfg_i.ie_req) || (flag_fin_o && cfg_i.ie_fin));
  assign dma_req_o = cfg_i.dma_on && cfg_i.run && free_ok;
endmodule

// File: rtl/pixfe_top.sv
module pixfe_top
  import pixfe_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          pix_valid,
  output logic [31:0]   pix_data,
  input  logic          pix_ready,
  input  logic          xfer_done,
  output logic          cfg_run,
  output logic [12:0]   cfg_len,
  output logic [2:0]    cfg_order,
  output logic [5:0]    cfg_t1h,
  output logic [4:0]    cfg_t1l,
  output logic [4:0]    cfg_t0h,
  output logic [5:0]    cfg_t0l,
  output logic [12:0]   cfg_tlatch,
  output logic [9:0]    cfg_npix,
  output logic          irq,
  output logic          dma_req
);
  cfg_t          cfg;
  logic          flush, push, stat_wr, empty, full, flag_req, flag_fin;
  logic [LW-1:0] level;

  pixfe_regs #(.LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
    .level_i(level), .flag_req_i(flag_req), .flag_fin_i(flag_fin),
    .cfg_o(cfg), .flush_o(flush), .push_o(push), .stat_wr_o(stat_wr)
  );

  pixfe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .push_i(push),
    .push_data_i(bus_wdata), .pop_i(pix_valid && pix_ready),
    .head_o(pix_data), .empty_o(empty), .full_o(full), .level_o(level)
  );

  pixfe_evt #(.DEPTH(DEPTH), .LW(LW)) u_evt (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .level_i(level),
    .xfer_done(xfer_done), .stat_wr_i(stat_wr), .stat_w1c_i(bus_wdata[1:0]),
    .flag_req_o(flag_req), .flag_fin_o(flag_fin), .irq_o(irq), .dma_req_o(dma_req)
  );

  assign pix_valid  = cfg.run && !empty;
  assign cfg_run    = cfg.run;
  assign cfg_len    = cfg.len;
  assign cfg_order  = cfg.order;
  assign cfg_t1h    = cfg.t1h;
  assign cfg_t1l    = cfg.t1l;
  assign cfg_t0h    = cfg.t0h;
  assign cfg_t0l    = cfg.t0l;
  assign cfg_tlatch = cfg.tlatch;
  assign cfg_npix   = cfg.npix;
endmodule

// File: rtl/pixfe_chk.sv
module pixfe_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [31:0]   pix_data,
  input logic          xfer_done,
  input logic          cfg_run,
  input logic [LW-1:0] level,
  input logic          flag_req,
  input logic          flag_fin,
  input logic          dma_on,
  input logic [4:0]    trig,
  input logic          ie_glob,
  input logic          irq,
  input logic          dma_req
);
  logic ctrl_wr, data_wr;
  assign ctrl_wr = bus_wr && (bus_addr == 6'h00);
  assign data_wr = bus_wr && (bus_addr == 6'h14);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(level) == DEPTH) && data_wr && !(pix_valid && pix_ready) && !ctrl_wr
    |=> 32'(level) == DEPTH);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready && !xfer_done && !ctrl_wr
    |=> pix_valid && $stable(pix_data));

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && bus_wdata[0] && !cfg_run |=> level == '0);

  p_req_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_run && !dma_on && (32'(level) <= 32'(trig)) |=> flag_req);

  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !ctrl_wr |=> flag_fin && !cfg_run);

  p_irq_glob_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_glob && (flag_req || flag_fin));

  p_dma_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cfg_run && dma_on);
endmodule

bind pixfe_top pixfe_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_data(pix_data), .xfer_done(xfer_done), .cfg_run(cfg_run),
  .level(level), .flag_req(flag_req), .flag_fin(flag_fin),
  .dma_on(cfg.dma_on), .trig(cfg.trig), .ie_glob(cfg.ie_glob),
  .irq(irq), .dma_req(dma_req)
);

// File: tb/tb_pixfe_top.sv
module tb_pixfe_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid, pix_ready = 1'b0, xfer_done = 1'b0;
  logic [31:0] pix_data;
  logic        cfg_run;
  logic [12:0] cfg_len, cfg_tlatch;
  logic [2:0]  cfg_order;
  logic [5:0]  cfg_t1h, cfg_t0l;
  logic [4:0]  cfg_t1l, cfg_t0h;
  logic [9:0]  cfg_npix;
  logic        irq, dma_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pixfe_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .xfer_done(xfer_done),
    .cfg_run(cfg_run), .cfg_len(cfg_len), .cfg_order(cfg_order),
    .cfg_t1h(cfg_t1h), .cfg_t1l(cfg_t1l), .cfg_t0h(cfg_t0h), .cfg_t0l(cfg_t0l),
    .cfg_tlatch(cfg_tlatch), .cfg_npix(cfg_npix), .irq(irq), .dma_req(dma_req)
  );

  // {offset, write value, expected readback}
  localparam int NV = 11;
  localparam logic [69:0] VEC [NV] = '{
    {6'h00, 32'hFFFF_FFFE, 32'h1FFF_01C0},
    {6'h04, 32'hFFFF_FFFF, 32'h07FF_07FF},
    {6'h0C, 32'hFFFF_FFFF, 32'h1FFF_03FF},
    {6'h18, 32'hFFFF_FFFF, 32'h0000_003F},
    {6'h1C, 32'hFFFF_FFFF, 32'h0000_0023},
    {6'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h18, 32'h0000_0010, 32'h0000_0010},
    {6'h1C, 32'h0000_0000, 32'h0000_0000},
    {6'h00, 32'h0015_0080, 32'h0015_0080},
    {6'h04, 32'h02A7_0214, 32'h02A7_0214},
    {6'h0C, 32'h0123_02A5, 32'h0123_02A5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(6'(a * 4), r);
      check("R1 reg", r, 32'h0);
    end
    check("R1 outs", {29'b0, pix_valid, irq, dma_req}, 32'h0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], r);
      check("R2 readback", r, VEC[i][31:0]);
    end
    rd(6'h14, r);
    check("R2 data port reads 0", r, 32'h0);

    // R11 config outputs
    check("R11 ctrl", {18'b0, cfg_len, cfg_order}, {18'b0, 13'h15, 3'd2});
    check("R11 bit timing", {10'b0, cfg_t1h, cfg_t1l, cfg_t0h, cfg_t0l},
          {10'b0, 6'd21, 5'd7, 5'd8, 6'd20});
    check("R11 latch", {9'b0, cfg_tlatch, cfg_npix}, {9'b0, 13'h123, 10'h2A5});

    // R3 level, R4 gating while stopped
    for (int k = 0; k < 3; k++) wr(6'h14, 32'h5000 + k);
    rd(6'h20, r);
    check("R3 level 3", r, 32'h0000_0C00);
    check("R4 no valid while stopped", {31'b0, pix_valid}, 32'h0);

    // R5 flush on run start
    wr(6'h00, 32'h1);
    rd(6'h20, r);
    check("R5 flushed", (r >> 10) & 32'h3F, 32'h0);

    // R3 fill beyond full
    for (int k = 0; k < 34; k++) wr(6'h14, 32'hA000 + k);
    rd(6'h20, r);
    check("R3 full level", (r >> 10) & 32'h3F, 32'd32);
    idle(2);
    check("R4 held while not ready", pix_data, 32'hA000);

    // R4 drain in order
    for (int k = 0; k < 32; k++) begin
      check("R4 valid", {31'b0, pix_valid}, 32'h1);
      check("R4 order", pix_data, 32'hA000 + k);
      pix_ready = 1'b1;
      @(negedge clk);
      pix_ready = 1'b0;
    end
    check("R3 drops after full", {31'b0, pix_valid}, 32'h0);

    // R6 CPU request flag, R9 irq
    wr(6'h18, 32'h04);
    idle(1);
    rd(6'h20, r);
    check("R6 request flag", r & 32'h3, 32'h2);
    wr(6'h1C, 32'h22);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(6'h1C, 32'h02);
    check("R9 irq no global", {31'b0, irq}, 32'h0);
    wr(6'h1C, 32'h21);
    check("R9 irq flag unenabled", {31'b0, irq}, 32'h0);

    // R7 finish
    done_pulse();
    rd(6'h20, r);
    check("R7 finish flag", r & 32'h1, 32'h1);
    rd(6'h00, r);
    check("R7 run cleared", r & 32'h1, 32'h0);
    check("R9 irq finish", {31'b0, irq}, 32'h1);

    // R8 write-one-to-clear
    wr(6'h20, 32'h0000_FFFE);
    rd(6'h20, r);
    check("R8 clear req only", r & 32'h3, 32'h1);
    wr(6'h20, 32'h1);
    rd(6'h20, r);
    check("R8 clear finish", r & 32'h3, 32'h0);
    check("R9 irq off", {31'b0, irq}, 32'h0);

    // R10 DMA request
    wr(6'h18, 32'h30);
    wr(6'h00, 32'h1);
    idle(1);
    check("R10 dma req empty", {31'b0, dma_req}, 32'h1);
    rd(6'h20, r);
    check("R6 no request with dma", r & 32'h3, 32'h0);
    for (int k = 0; k < 16; k++) wr(6'h14, 32'hB000 + k);
    check("R10 free equals trigger", {31'b0, dma_req}, 32'h1);
    wr(6'h14, 32'hB010);
    check("R10 free below trigger", {31'b0, dma_req}, 32'h0);
    done_pulse();
    check("R10 no req after stop", {31'b0, dma_req}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule